// File: doc/BRIEF.md
# Floating-Point Register Stack Manager

This block keeps the bookkeeping for an eight-slot floating-point register file that software sees as a stack. A 3-bit top pointer wraps modulo eight. Every physical slot carries a tag that marks it as holding a value or as empty. Operands are named relative to the top pointer, and the block turns each relative name into a physical slot. Pushes and pops move the pointer and update the tags. Two pointer-only commands rotate the stack without touching any contents.

A single-cycle command strobe carries an opcode, a relative index and push data. The block answers one clock later. It returns read data with a valid pulse, a stack-underflow pulse or a stack-overflow pulse, and a condition bit that records the direction of the most recent stack fault. The current pointer and the empty-tag vector are visible at all times. A fault leaves the pointer, the tags and the slot contents exactly as they were.

Top module: `fp_reg_stack`

## Requirements
- R1: After the active-low asynchronous reset, the top pointer is 0, all eight empty tags are 1, and rd_valid_o, underflow_o, overflow_o, c1_o and rd_data_o are all 0.
- R2: Opcode 5 (read) selects physical slot (top + idx) mod 8. If that slot holds a value, the next clock gives its data on rd_data_o with a one-cycle rd_valid_o pulse. The pointer and the tags do not change.
- R3: Opcode 1 (push) aims at slot (top − 1) mod 8. If that slot is empty, the pointer takes that value (0 wraps to 7), the slot stores cmd_wdata_i and its empty tag clears.
- R4: A push whose target slot already holds a value raises a one-cycle overflow_o pulse and sets c1_o to 1. The pointer, the tags and the contents do not change.
- R5: Opcode 2 (pop) on a non-empty top slot presents that slot's data with rd_valid_o, sets the slot's empty tag and adds one to the pointer modulo 8.
- R6: A pop of an empty top slot, or a read of an empty slot, raises a one-cycle underflow_o pulse, clears c1_o to 0 and keeps rd_valid_o low. The pointer and the tags do not change.
- R7: Opcode 4 (decrement) subtracts one from the pointer, with 0 wrapping to 7. It changes no tag and no slot contents.
- R8: Opcode 3 (increment) adds one to the pointer modulo 8 and changes no tag and no contents.
- R9: Opcodes 0, 6 and 7, and any cycle without cmd_valid_i, change nothing. c1_o keeps its value until the next fault, and rd_data_o reads 0 whenever rd_valid_o is low.
- R10: All results appear at the clock edge that samples the command. top_o and tag_empty_o show the updated state, and the pulse outputs last exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Opcode: 1 push, 2 pop, 3 increment, 4 decrement, 5 read |
| cmd_idx_i | input | PTR_W | Register index relative to the top (read only) |
| cmd_wdata_i | input | DATA_W | Data to push |
| rd_data_o | output | DATA_W | Data from a read or a pop, 0 otherwise |
| rd_valid_o | output | 1 | rd_data_o is valid this cycle |
| top_o | output | PTR_W | Current top pointer |
| tag_empty_o | output | 2**PTR_W | Empty tag of each physical slot |
| underflow_o | output | 1 | Stack-underflow pulse |
| overflow_o | output | 1 | Stack-overflow pulse |
| c1_o | output | 1 | Direction of the last stack fault: 1 overflow, 0 underflow |

## Verification
Two things happen in the same cycle in this block. A pop reads out the top slot while it clears that slot's tag and moves the pointer. A push checks for overflow against the slot it is about to claim while it moves the pointer. The bench pops values back immediately after pushing them, and it fills all eight slots so that the next push wraps the pointer from 0 to 7 and hits an occupied slot. A behavioural model of pointer, tags and contents predicts every output after each command, and any difference in data, pointer, tags, fault pulses or c1_o counts as a miscompare. A long pseudo-random command stream then mixes both cases with reads of empty slots and pointer rotations.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;
  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_PUSH = 3'd1,
    OP_POP  = 3'd2,
    OP_INC  = 3'd3,
    OP_DEC  = 3'd4,
    OP_READ = 3'd5
  } stk_op_e;
endpackage

// File: rtl/fpstk_ptr.sv
module fpstk_ptr #(
  parameter int PTR_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [PTR_W-1:0] top_o
);
  logic [PTR_W-1:0] top_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    top_q <= '0;
    else if (inc_i) top_q <= top_q + 1'b1;
    else if (dec_i) top_q <= top_q - 1'b1;
  end

  assign top_o = top_q;
endmodule

// File: rtl/fpstk_regs.sv
module fpstk_regs #(
  parameter int DATA_W = 16,
  parameter int PTR_W  = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [PTR_W-1:0]        wr_slot_i,
  input  logic [DATA_W-1:0]       wr_data_i,
  input  logic                    clr_en_i,
  input  logic [PTR_W-1:0]        clr_slot_i,
  input  logic [PTR_W-1:0]        rd_slot_i,
  output logic [DATA_W-1:0]       rd_data_o,
  output logic [(1<<PTR_W)-1:0]   valid_o
);
  localparam int DEPTH = 1 << PTR_W;

  logic [DEPTH-1:0]  wr_hit, clr_hit, valid_q;
  logic [DATA_W-1:0] data_q [DEPTH];

  // one-hot slot decode
  for (genvar g = 0; g < DEPTH; g++) begin : g_dec
    assign wr_hit[g]  = wr_en_i  && (wr_slot_i  == PTR_W'(g));
    assign clr_hit[g] = clr_en_i && (clr_slot_i == PTR_W'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      for (int k = 0; k < DEPTH; k++) data_q[k] <= '0;
    end else begin
      for (int k = 0; k < DEPTH; k++) begin
        if (wr_hit[k]) begin
          valid_q[k] <= 1'b1;
          data_q[k]  <= wr_data_i;
        end else if (clr_hit[k]) begin
          valid_q[k] <= 1'b0;
        end
      end
    end
  end

  assign rd_data_o = data_q[rd_slot_i];
  assign valid_o   = valid_q;
endmodule

// File: rtl/fpstk_resp.sv
module fpstk_resp #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  logic              unf_i,
  input  logic              ovf_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              underflow_o,
  output logic              overflow_o,
  output logic              c1_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o   <= '0;
      rd_valid_o  <= 1'b0;
      underflow_o <= 1'b0;
      overflow_o  <= 1'b0;
      c1_o        <= 1'b0;
    end else begin
      rd_data_o   <= hit_i ? data_i : '0;
      rd_valid_o  <= hit_i;
      underflow_o <= unf_i;
      overflow_o  <= ovf_i;
      // c1 records the direction of the latest stack fault
      if (ovf_i)      c1_o <= 1'b1;
      else if (unf_i) c1_o <= 1'b0;
    end
  end
endmodule

// File: rtl/fp_reg_stack.sv
module fp_reg_stack
  import fpstk_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PTR_W  = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cmd_valid_i,
  input  logic [2:0]            cmd_op_i,
  input  logic [PTR_W-1:0]      cmd_idx_i,
  input  logic [DATA_W-1:0]     cmd_wdata_i,
  output logic [DATA_W-1:0]     rd_data_o,
  output logic                  rd_valid_o,
  output logic [PTR_W-1:0]      top_o,
  output logic [(1<<PTR_W)-1:0] tag_empty_o,
  output logic                  underflow_o,
  output logic                  overflow_o,
  output logic                  c1_o
);
  localparam int DEPTH = 1 << PTR_W;

  logic [PTR_W-1:0]  top_q, push_slot, rel_slot, rd_slot;
  logic [DEPTH-1:0]  valid;
  logic [DATA_W-1:0] slot_data;
  logic is_push, is_pop, is_inc, is_dec, is_read;
  logic push_ok, push_ovf, pop_ok, pop_unf, read_ok, read_unf;

  always_comb begin
    is_push = cmd_valid_i && (cmd_op_i == OP_PUSH);
    is_pop  = cmd_valid_i && (cmd_op_i == OP_POP);
    is_inc  = cmd_valid_i && (cmd_op_i == OP_INC);
    is_dec  = cmd_valid_i && (cmd_op_i == OP_DEC);
    is_read = cmd_valid_i && (cmd_op_i == OP_READ);

    push_slot = top_q - 1'b1;
    rel_slot  = top_q + cmd_idx_i;
    rd_slot   = is_read ? rel_slot : top_q;

    push_ok  = is_push &&  !valid[push_slot];
    push_ovf = is_push &&   valid[push_slot];
    pop_ok   = is_pop  &&   valid[top_q];
    pop_unf  = is_pop  &&  !valid[top_q];
    read_ok  = is_read &&   valid[rel_slot];
    read_unf = is_read &&  !valid[rel_slot];
  end

  fpstk_ptr #(.PTR_W(PTR_W)) i_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (is_inc || pop_ok),
    .dec_i  (is_dec || push_ok),
    .top_o  (top_q)
  );

  fpstk_regs #(.DATA_W(DATA_W), .PTR_W(PTR_W)) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (push_ok),
    .wr_slot_i  (push_slot),
    .wr_data_i  (cmd_wdata_i),
    .clr_en_i   (pop_ok),
    .clr_slot_i (top_q),
    .rd_slot_i  (rd_slot),
    .rd_data_o  (slot_data),
    .valid_o    (valid)
  );

  fpstk_resp #(.DATA_W(DATA_W)) i_resp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hit_i       (pop_ok || read_ok),
    .unf_i       (pop_unf || read_unf),
    .ovf_i       (push_ovf),
    .data_i      (slot_data),
    .rd_data_o   (rd_data_o),
    .rd_valid_o  (rd_valid_o),
    .underflow_o (underflow_o),
    .overflow_o  (overflow_o),
    .c1_o        (c1_o)
  );

  assign top_o       = top_q;
  assign tag_empty_o = ~valid;
endmodule

// File: rtl/fpstk_chk.sv
module fpstk_chk
  import fpstk_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PTR_W  = 3
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  cmd_valid_i,
  input logic [2:0]            cmd_op_i,
  input logic [PTR_W-1:0]      cmd_idx_i,
  input logic [DATA_W-1:0]     cmd_wdata_i,
  input logic [DATA_W-1:0]     rd_data_o,
  input logic                  rd_valid_o,
  input logic [PTR_W-1:0]      top_o,
  input logic [(1<<PTR_W)-1:0] tag_empty_o,
  input logic                  underflow_o,
  input logic                  overflow_o,
  input logic                  c1_o
);
  AST_PUSH_CLAIMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_op_i == OP_PUSH && tag_empty_o[top_o - 1'b1]
    |=> top_o == $past(top_o) - 1'b1 && !tag_empty_o[top_o] && rd_data_o == '0); // R3

  AST_NO_OVERFLOW_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_op_i == OP_PUSH && !tag_empty_o[top_o - 1'b1]
    |=> overflow_o && c1_o && $stable(top_o) && $stable(tag_empty_o)); // R4

  AST_POP_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_op_i == OP_POP && !tag_empty_o[top_o]
    |=> rd_valid_o && tag_empty_o[$past(top_o)] && top_o == $past(top_o) + 1'b1); // R5

  AST_READ_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_op_i == OP_READ && tag_empty_o[top_o + cmd_idx_i]
    |=> underflow_o && !c1_o && !rd_valid_o && $stable(top_o)); // R6

  AST_DEC_ROTATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_op_i == OP_DEC
    |=> top_o == $past(top_o) - 1'b1 && $stable(tag_empty_o)); // R7

  AST_INC_ROTATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_op_i == OP_INC
    |=> top_o == $past(top_o) + 1'b1 && $stable(tag_empty_o)); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> !rd_valid_o && !underflow_o && !overflow_o
                     && $stable(top_o) && $stable(tag_empty_o) && $stable(c1_o)); // R9

  AST_ONE_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(underflow_o && overflow_o) && !(rd_valid_o && underflow_o)); // R10
endmodule

bind fp_reg_stack fpstk_chk #(.DATA_W(DATA_W), .PTR_W(PTR_W)) i_chk (.*);

// File: tb/test_fp_reg_stack.sv
`timescale 1ns/1ps
module test_fp_reg_stack;
  localparam int DW = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cmd_valid_i = 1'b0;
  logic [2:0]    cmd_op_i = '0;
  logic [2:0]    cmd_idx_i = '0;
  logic [DW-1:0] cmd_wdata_i = '0;
  logic [DW-1:0] rd_data_o;
  logic          rd_valid_o;
  logic [2:0]    top_o;
  logic [7:0]    tag_empty_o;
  logic          underflow_o, overflow_o, c1_o;

  always #2 clk_i = ~clk_i;

  fp_reg_stack #(.DATA_W(DW), .PTR_W(3)) i_fp_reg_stack (.*);

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference model
  int          m_top;
  bit          m_vld [8];
  logic [DW-1:0] m_mem [8];
  logic [DW-1:0] e_rd;
  bit          e_rv, e_unf, e_ovf, e_c1;

  function automatic logic [7:0] m_empty();
    logic [7:0] v;
    for (int k = 0; k < 8; k++) v[k] = !m_vld[k];
    return v;
  endfunction

  task automatic compare(string req);
    vectors++;
    if (top_o !== 3'(m_top) || tag_empty_o !== m_empty() || rd_valid_o !== e_rv ||
        rd_data_o !== e_rd || underflow_o !== e_unf || overflow_o !== e_ovf || c1_o !== e_c1) begin
      fails++;
      $display("FAIL %s: got top=%0d tags=%b rv=%b rd=%h unf=%b ovf=%b c1=%b exp top=%0d tags=%b rv=%b rd=%h unf=%b ovf=%b c1=%b",
               req, top_o, tag_empty_o, rd_valid_o, rd_data_o, underflow_o, overflow_o, c1_o,
               m_top, m_empty(), e_rv, e_rd, e_unf, e_ovf, e_c1);
    end
  endtask

  task automatic apply(bit vld, logic [2:0] op, logic [2:0] idx, logic [DW-1:0] d, string req);
    int s;
    e_rv = 0; e_unf = 0; e_ovf = 0; e_rd = '0;
    if (vld) begin
      case (op)
        3'd1: begin
          s = (m_top + 7) % 8;
          if (m_vld[s]) begin e_ovf = 1; e_c1 = 1; end
          else begin m_top = s; m_vld[s] = 1; m_mem[s] = d; end
        end
        3'd2: begin
          if (m_vld[m_top]) begin
            e_rv = 1; e_rd = m_mem[m_top]; m_vld[m_top] = 0; m_top = (m_top + 1) % 8;
          end else begin e_unf = 1; e_c1 = 0; end
        end
        3'd3: m_top = (m_top + 1) % 8;
        3'd4: m_top = (m_top + 7) % 8;
        3'd5: begin
          s = (m_top + int'(idx)) % 8;
          if (m_vld[s]) begin e_rv = 1; e_rd = m_mem[s]; end
          else begin e_unf = 1; e_c1 = 0; end
        end
        default: ;
      endcase
    end
    cmd_valid_i = vld; cmd_op_i = op; cmd_idx_i = idx; cmd_wdata_i = d;
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    compare(req);
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung run, exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    m_top = 0; e_c1 = 0; e_rv = 0; e_unf = 0; e_ovf = 0; e_rd = '0;
    for (int k = 0; k < 8; k++) begin m_vld[k] = 0; m_mem[k] = '0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare("R1");

    apply(1, 3'd5, 3'd0, '0, "R6");          // read of empty
    apply(1, 3'd2, 3'd0, '0, "R6");          // pop of empty
    for (int k = 0; k < 8; k++) apply(1, 3'd1, 3'd0, DW'(16'h1100 + k), "R3"); // 0 wraps to 7
    apply(1, 3'd1, 3'd0, 16'hdead, "R4");    // ninth push overflows
    apply(0, 3'd0, 3'd0, '0, "R9");          // c1 holds
    for (int k = 0; k < 8; k++) apply(1, 3'd5, 3'(k), '0, "R2");
    apply(1, 3'd4, 3'd0, '0, "R7");
    apply(1, 3'd4, 3'd0, '0, "R7");
    apply(1, 3'd3, 3'd0, '0, "R8");
    apply(1, 3'd3, 3'd0, '0, "R8");
    apply(1, 3'd0, 3'd0, 16'hbeef, "R9");
    apply(1, 3'd6, 3'd2, 16'hbeef, "R9");
    apply(1, 3'd7, 3'd1, 16'hbeef, "R9");
    for (int k = 0; k < 9; k++) apply(1, 3'd2, 3'd0, '0, "R5");  // last one underflows
    apply(1, 3'd4, 3'd0, '0, "R7");          // 0 -> 7 on empty stack
    apply(1, 3'd1, 3'd0, 16'h0042, "R3");
    apply(1, 3'd2, 3'd0, '0, "R5");          // pop right after push
    apply(1, 3'd5, 3'd3, '0, "R6");

    lfsr = 16'hace1;
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      apply(lfsr[15:14] != 2'b00, lfsr[2:0], lfsr[5:3], {lfsr[7:0], lfsr[15:8]}, "R10");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule